// File: doc/BRIEF.md
# Multiplexer-Steered Add/Subtract/AND Arithmetic Unit

This block is a purely combinational arithmetic unit for a narrow datapath. It takes two operands and two control bits. It returns a result of the operand width and a signed-overflow flag. One adder serves both addition and subtraction. For subtraction, the second operand passes through a bank of XOR gates that invert it, and the carry-in of the ripple chain is forced to one. The chain therefore computes A + ~B + 1.

A bank of 2:1 multiplexers, one per result bit, shares a single select line. That line chooses between the adder output and the bitwise AND of the operands. The surrounding logic drives the operands and controls, and it samples the result and flag once they have settled. The block holds no state. The default width is four bits. Add and subtract treat the operands as two's complement values.

Top module: `mux_alu`

## Requirements
- R1: With `sel_arith` = 0, `result` equals the bitwise AND of `opnd_a` and `opnd_b`.
- R2: With `sel_arith` = 0, the level of `do_sub` has no effect on `result` or `ovf`.
- R3: With `sel_arith` = 0, `ovf` is 0 for every operand pair.
- R4: With `sel_arith` = 1 and `do_sub` = 0, `result` equals (`opnd_a` + `opnd_b`) modulo 16. The carry out of bit 3 is dropped.
- R5: With `sel_arith` = 1 and `do_sub` = 1, `result` equals (`opnd_a` − `opnd_b`) modulo 16, formed as `opnd_a` + ~`opnd_b` + 1.
- R6: When adding, `ovf` is 1 exactly when the signed sum of the operands lies outside −8..7. The operands are read as two's complement, with bit 3 as the sign.
- R7: When subtracting, `ovf` is 1 exactly when the signed difference `opnd_a` − `opnd_b` lies outside −8..7. For example, 0 − 8 gives result 8 with `ovf` = 1.
- R8: Subtracting zero returns `opnd_a` unchanged with `ovf` = 0, even though the ripple chain produces a carry out. Subtracting an operand from itself gives 0 with `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 4 | First operand |
| opnd_b | input | 4 | Second operand (the subtrahend when subtracting) |
| sel_arith | input | 1 | 1 selects the adder/subtractor output, 0 selects the bitwise AND |
| do_sub | input | 1 | 1 subtracts, 0 adds. Also acts as the adder carry-in |
| result | output | 4 | Computed value |
| ovf | output | 1 | Signed overflow of the selected arithmetic operation |

## Verification
The checker treats the block as settled logic. Each property is evaluated only after the inputs have been applied and the outputs have been recomputed. It also assumes that every input holds a known 0 or 1, never X or Z. The bench meets both conditions. It drives every input from one task on the rising clock edge and reads the outputs only on the falling edge. It also gives every input a defined value before the first sample, both in the exhaustive 1024-vector sweep and in the seeded random and directed vectors.

// File: rtl/alu_pkg.sv
// Package alu_pkg
// Shared parameters and the control-word type for the add/subtract/AND unit.
// Assumes the operand width is at least two bits.
package alu_pkg;
    localparam int unsigned ALU_W_DEF = 4;

    // Decoded operation, kept for readability in the top module.
    typedef enum logic [1:0] {
        OP_AND_A = 2'b00,
        OP_AND_B = 2'b01,
        OP_ADD   = 2'b10,
        OP_SUB   = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu_full_adder.sv
// Module alu_full_adder
// One-bit full adder, the cell of the ripple chain. Pure combinational.
module alu_full_adder (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    // Sum and carry of one bit position.
    always_comb begin
        s_o = x_i ^ y_i ^ c_i;
        c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
    end
endmodule

// File: rtl/alu_ripple_adder.sv
// Module alu_ripple_adder
// Ripple-carry adder built from W full-adder cells. It exposes the carry
// into the top bit and the carry out of it, for overflow detection.
// Assumes W >= 2.
module alu_ripple_adder #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         c_msb_in_o,
    output logic         cout_o
);
    localparam int unsigned MSB = W - 1;

    logic [W:0] carry;

    // Chain input takes the external carry.
    always_comb carry[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_cell
        alu_full_adder u_fa (
            .x_i (x_i[i]),
            .y_i (y_i[i]),
            .c_i (carry[i]),
            .s_o (sum_o[i]),
            .c_o (carry[i+1])
        );
    end

    // Bring out the carries around the sign bit.
    always_comb begin
        c_msb_in_o = carry[MSB];
        cout_o     = carry[W];
    end
endmodule

// File: rtl/alu_xor_bank.sv
// Module alu_xor_bank
// Conditionally inverts a word: each bit is XORed with the shared control.
module alu_xor_bank #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] d_i,
    input  logic         inv_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_xor
        // One XOR gate per bit position.
        always_comb q_o[i] = d_i[i] ^ inv_i;
    end
endmodule

// File: rtl/alu_mux_bank.sv
// Module alu_mux_bank
// W two-input multiplexers that share one select line (1 picks in1_i).
module alu_mux_bank #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] in0_i,
    input  logic [W-1:0] in1_i,
    input  logic         sel_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_mux
        // Per-bit 2:1 selection.
        always_comb q_o[i] = sel_i ? in1_i[i] : in0_i[i];
    end
endmodule

// File: rtl/mux_alu.sv
// Module mux_alu
// Combinational add/subtract/AND unit. sel_arith=1 routes the shared adder
// out, sel_arith=0 routes A AND B. do_sub inverts B and feeds the carry-in.
// Overflow is signed and is held at 0 while AND is selected.
// Assumes settled, known inputs. No state, so no clock or reset.
module mux_alu
    import alu_pkg::*;
#(
    parameter int unsigned W = ALU_W_DEF
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         sel_arith,
    input  logic         do_sub,
    output logic [W-1:0] result,
    output logic         ovf
);
    alu_op_e     op;
    logic [W-1:0] b_mod;
    logic [W-1:0] arith_sum;
    logic [W-1:0] and_word;
    logic         c_into_msb;
    logic         c_out_msb;

    // Decode the two control bits into a named operation.
    always_comb op = alu_op_e'({sel_arith, do_sub});

    alu_xor_bank #(.W(W)) u_inv (
        .d_i   (opnd_b),
        .inv_i (do_sub),
        .q_o   (b_mod)
    );

    alu_ripple_adder #(.W(W)) u_add (
        .x_i        (opnd_a),
        .y_i        (b_mod),
        .cin_i      (do_sub),
        .sum_o      (arith_sum),
        .c_msb_in_o (c_into_msb),
        .cout_o     (c_out_msb)
    );

    // Bitwise AND path.
    always_comb and_word = opnd_a & opnd_b;

    alu_mux_bank #(.W(W)) u_sel (
        .in0_i (and_word),
        .in1_i (arith_sum),
        .sel_i (sel_arith),
        .q_o   (result)
    );

    // Signed overflow: carry into sign bit differs from carry out, arithmetic only.
    always_comb ovf = ((op == OP_ADD) || (op == OP_SUB)) && (c_into_msb ^ c_out_msb);
endmodule

// File: rtl/mux_alu_checker.sv
// Module mux_alu_checker
// Immediate properties on the settled ports of mux_alu. Assumes known inputs.
module mux_alu_checker #(
    parameter int unsigned W = 4
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         sel_arith,
    input logic         do_sub,
    input logic [W-1:0] result,
    input logic         ovf
);
    logic [W-1:0] add_ref;
    logic [W-1:0] sub_ref;

    // Behavioural sums for comparison against the ripple chain.
    always_comb begin
        add_ref = opnd_a + opnd_b;
        sub_ref = opnd_a - opnd_b;
    end

    // Port-level properties, evaluated whenever the ports settle.
    always_comb begin
        AST_AND_PATH: assert (sel_arith || result == (opnd_a & opnd_b)) else $error("and path"); // R1
        AST_NO_OVERFLOW: assert (sel_arith || !ovf) else $error("ovf on AND"); // R3
        AST_ADD_PATH: assert (!sel_arith || do_sub || result == add_ref) else $error("add path"); // R4
        AST_SUB_PATH: assert (!sel_arith || !do_sub || result == sub_ref) else $error("sub path"); // R5
        AST_ADD_OVF: assert (!sel_arith || do_sub ||
            ovf == ((opnd_a[W-1] == opnd_b[W-1]) && (result[W-1] != opnd_a[W-1]))) else $error("add ovf"); // R6
        AST_SUB_OVF: assert (!sel_arith || !do_sub ||
            ovf == ((opnd_a[W-1] != opnd_b[W-1]) && (result[W-1] != opnd_a[W-1]))) else $error("sub ovf"); // R7
        AST_SUB_ZERO: assert (!(sel_arith && do_sub && opnd_b == '0) || (result == opnd_a && !ovf)) else $error("sub zero"); // R8
    end
endmodule

bind mux_alu mux_alu_checker #(.W(W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .sel_arith (sel_arith),
    .do_sub    (do_sub),
    .result    (result),
    .ovf       (ovf)
);

// File: tb/sim_mux_alu.sv
// Bench sim_mux_alu: exhaustive sweep, seeded random and directed corners,
// compared against signed-integer reference functions.
module sim_mux_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a = '0;
    logic [3:0] b = '0;
    logic       sa = 1'b0;
    logic       sb = 1'b0;
    logic [3:0] res;
    logic       ov;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    // 250 MHz clock.
    always #2 clk = ~clk;

    mux_alu u0 (
        .opnd_a    (a),
        .opnd_b    (b),
        .sel_arith (sa),
        .do_sub    (sb),
        .result    (res),
        .ovf       (ov)
    );

    // Signed value of a 4-bit word.
    function automatic int sval(input logic [3:0] v);
        return v[3] ? int'(v) - 16 : int'(v);
    endfunction

    // Reference result from the requirements.
    function automatic logic [3:0] exp_res(input logic [3:0] x, input logic [3:0] y,
                                           input logic s, input logic d);
        int t;
        if (!s) return x & y;
        t = d ? (int'(x) - int'(y)) : (int'(x) + int'(y));
        return 4'(t & 15);
    endfunction

    // Reference overflow from the requirements.
    function automatic logic exp_ovf(input logic [3:0] x, input logic [3:0] y,
                                     input logic s, input logic d);
        int t;
        if (!s) return 1'b0;
        t = d ? (sval(x) - sval(y)) : (sval(x) + sval(y));
        return (t > 7) || (t < -8);
    endfunction

    // Tag naming the requirement a vector exercises.
    function automatic string tag_of(input logic s, input logic d);
        if (!s) return "R1/R3";
        return d ? "R5/R7" : "R4/R6";
    endfunction

    // Apply one vector at a rising edge, compare at the following falling edge.
    task automatic apply(input logic [3:0] x, input logic [3:0] y,
                         input logic s, input logic d, input string tag);
        logic [3:0] er;
        logic       eo;
        @(posedge clk);
        a = x; b = y; sa = s; sb = d;
        @(negedge clk);
        er = exp_res(x, y, s, d);
        eo = exp_ovf(x, y, s, d);
        n_chk++;
        if (res !== er || ov !== eo) begin
            n_bad++;
            $display("FAIL %s a=%0d b=%0d sel=%0b sub=%0b: got res=%0d ovf=%0b, expected res=%0d ovf=%0b",
                     tag, x, y, s, d, res, ov, er, eo);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] r0;
        logic       o0;
        void'($urandom(32'd2417));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all inputs zero gives zero outputs (R1).
        apply(4'd0, 4'd0, 1'b0, 1'b0, "R1");
        // Exhaustive sweep over both control bits and all operand pairs.
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < 2; d++)
                for (int x = 0; x < 16; x++)
                    for (int y = 0; y < 16; y++)
                        apply(4'(x), 4'(y), 1'(s), 1'(d), tag_of(1'(s), 1'(d)));
        // R2: do_sub toggled under AND select must leave both outputs unchanged.
        for (int k = 0; k < 64; k++) begin
            logic [3:0] rx;
            logic [3:0] ry;
            rx = 4'($urandom);
            ry = 4'($urandom);
            apply(rx, ry, 1'b0, 1'b0, "R2");
            r0 = res; o0 = ov;
            apply(rx, ry, 1'b0, 1'b1, "R2");
            n_chk++;
            if (res !== r0 || ov !== o0) begin
                n_bad++;
                $display("FAIL R2 do_sub changed AND output: got %0d/%0b expected %0d/%0b", res, ov, r0, o0);
            end
        end
        // Directed corners.
        apply(4'd5, 4'd0, 1'b1, 1'b1, "R8");   // minus zero: 5, no ovf
        apply(4'd8, 4'd0, 1'b1, 1'b1, "R8");   // -8 minus zero
        apply(4'd9, 4'd9, 1'b1, 1'b1, "R8");   // self subtract
        apply(4'd0, 4'd8, 1'b1, 1'b1, "R7");   // 0 - (-8) overflows
        apply(4'd7, 4'd1, 1'b1, 1'b0, "R6");   // 7 + 1 overflows
        apply(4'd8, 4'd8, 1'b1, 1'b0, "R6");   // -8 + -8 overflows, carry dropped
        apply(4'd15, 4'd1, 1'b1, 1'b0, "R4");  // wrap to zero, no ovf
        apply(4'd15, 4'd15, 1'b0, 1'b1, "R3"); // AND with do_sub high
        // Seeded random vectors across all controls.
        for (int k = 0; k < 300; k++) begin
            logic [3:0] rx;
            logic [3:0] ry;
            logic       rs;
            logic       rd;
            rx = 4'($urandom);
            ry = 4'($urandom);
            rs = 1'($urandom);
            rd = 1'($urandom);
            apply(rx, ry, rs, rd, tag_of(rs, rd));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule